// File: doc/BRIEF.md
# Banked Tile Transpose Buffer

This block turns a square tile of 32-bit words around its diagonal. The producer writes one full row of the tile per handshake. Once every row is in, the consumer pulls the tile out one column per handshake. Output beat j therefore carries column j of the input, which is row j of the transposed tile. The block serves as the corner-turn stage between a row-ordered producer and a consumer that wants the transposed order.

The storage is split into DIM single-ported banks, each one word wide and DIM words deep. A skewed placement puts element (r, c) in bank (r + c) mod DIM. With this placement, a full row touches every bank once and a full column also touches every bank once, so both take one cycle. A mode input selects the unskewed placement instead, with bank c for element (r, c). In that mode every word of a column sits in the same bank and a column read is serialised over DIM bank cycles. A counter reports the extra cycles this costs.

A phase flag separates the two halves of the work. While filling, only row writes are taken. While draining, only column reads are taken. The flag changes only when the current phase has fully completed.

Top module: `tbuf_transpose`

## Requirements
- R1: After reset the block is in the fill phase: drain_o=0, wr_rdy_o=1, rd_rdy_o=0, rd_dvalid_o=0 and conf_cnt_o=0.
- R2: In the fill phase wr_rdy_o is 1 in both modes, so every row write is accepted in the cycle it is presented. Row r is the r-th accepted write, with word c at wr_row_i[c*32 +: 32]. drain_o rises at the clock edge that accepts the 32nd row.
- R3: The fill phase is a barrier. Until all 32 rows have been accepted, rd_rdy_o stays 0, read requests produce no rd_dvalid_o, and they do not advance the column sequence.
- R4: In the drain phase wr_rdy_o is 0 and row writes are ignored. The tile that is read out is the one written before the drain began.
- R5: The k-th accepted column read (k = 0..31, in order) returns column k. Word r of rd_data_o (bits r*32 +: 32) equals word k of row r. rd_dvalid_o is high exactly in the cycle after each accepted read.
- R6: In skewed mode (pad_mode_i=1 at the first row write), rd_rdy_o is 1 throughout the drain, each column completes in one cycle, and conf_cnt_o stays 0.
- R7: In unskewed mode (pad_mode_i=0 at the first row write), a continuously requested column is accepted only after 31 cycles with rd_rdy_o low. conf_cnt_o grows by 31 per column and reaches 992 after the whole tile.
- R8: conf_cnt_o keeps its value after a drain ends. It is cleared by the edge that accepts the first row of the next tile.
- R9: After the 32nd column is accepted the block returns to the fill phase. The mode is sampled only when the first row of a tile is written, and later changes of pad_mode_i do not affect that tile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| pad_mode_i | input | 1 | 1 = skewed bank placement, 0 = unskewed; sampled at a tile's first row write |
| wr_vld_i | input | 1 | Row write request |
| wr_row_i | input | 1024 | Row data, word c at bits c*32 +: 32 |
| wr_rdy_o | output | 1 | Row write can be accepted (fill phase) |
| rd_vld_i | input | 1 | Column read request |
| rd_rdy_o | output | 1 | Column read is accepted this cycle |
| rd_dvalid_o | output | 1 | rd_data_o holds a completed column |
| rd_data_o | output | 1024 | Column data, word r = element of row r |
| drain_o | output | 1 | Phase flag: 1 = tile full and draining, 0 = filling |
| conf_cnt_o | output | 10 | Extra bank cycles spent in the current or last tile |

## Verification
The assertions assume that a read request, once raised in unskewed mode, stays high until it is accepted. The serialisation counter holds while the request is low, so a dropped request only delays the read. They also assume that reset is applied before the first handshake. The stimulus leaves random idle gaps only between handshakes, never inside a serialised column. It changes pad_mode_i freely after a tile's first row and during the drain, to show that only the sampled mode counts. It also presents writes during the drain and reads during the fill, to show that the phase flag blocks them.

// File: rtl/tbuf_pkg.sv
`timescale 1ns/1ps
package tbuf_pkg;

   // Fill/drain phase of the tile buffer
   typedef enum logic {
      PH_FILL  = 1'b0,
      PH_DRAIN = 1'b1
   } phase_e;

   // Elaboration choice for the bank placement mode source
   typedef enum logic [1:0] {
      MODE_RUNTIME  = 2'd0,   // follow pad_mode_i at the first row of a tile
      MODE_SKEW_FIX = 2'd1,   // always skewed placement
      MODE_FLAT_FIX = 2'd2    // always unskewed placement
   } mode_sel_e;

   // Largest value the extra-cycle counter can reach in one tile
   function automatic int unsigned conf_max(input int unsigned dim);
      return dim * (dim - 1);
   endfunction

endpackage

// File: rtl/tbuf_bank.sv
`timescale 1ns/1ps
// One single-ported bank: one write or one read per cycle at a shared address.
module tbuf_bank #(
   parameter int DEPTH  = 32,
   parameter int WORD_W = 32,
   parameter int AW     = $clog2(DEPTH)
) (
   input  logic              clk_i,
   input  logic              we_i,
   input  logic [AW-1:0]     addr_i,
   input  logic [WORD_W-1:0] wdata_i,
   output logic [WORD_W-1:0] rdata_o
);

   if (DEPTH < 2) begin : g_chk_depth
      $error("tbuf_bank: DEPTH must be at least 2");
   end

   logic [WORD_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk_i) begin
      if (we_i) begin
         mem_q[addr_i] <= wdata_i;
      end
   end

   assign rdata_o = mem_q[addr_i];

endmodule

// File: rtl/tbuf_ctrl.sv
`timescale 1ns/1ps
// Phase sequencing, row/column/serial counters, mode latch and extra-cycle counter.
module tbuf_ctrl
   import tbuf_pkg::*;
#(
   parameter int        DIM      = 32,
   parameter mode_sel_e MODE_SEL = MODE_RUNTIME,
   parameter int        IW       = $clog2(DIM),
   parameter int        CW       = $clog2(conf_max(DIM) + 1)
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          pad_mode_i,
   input  logic          wr_vld_i,
   input  logic          rd_vld_i,
   output logic          wr_rdy_o,
   output logic          rd_rdy_o,
   output logic          wr_fire_o,
   output logic          rd_fire_o,
   output logic          ser_step_o,
   output logic          drain_o,
   output logic          skew_o,
   output logic [IW-1:0] row_o,
   output logic [IW-1:0] col_o,
   output logic [IW-1:0] ser_o,
   output logic [CW-1:0] conf_o
);

   localparam logic [IW-1:0] LAST = IW'(DIM - 1);

   phase_e        phase_q;
   logic          mode_in;
   logic          mode_q;
   logic          mode_eff;
   logic          fill;
   logic          ser_done;
   logic          wr_fire;
   logic          rd_fire;
   logic          ser_step;
   logic [IW-1:0] row_q;
   logic [IW-1:0] col_q;
   logic [IW-1:0] ser_q;
   logic [CW-1:0] conf_q;

   // Mode source chosen at elaboration
   if (MODE_SEL == MODE_RUNTIME) begin : g_mode_rt
      assign mode_in = pad_mode_i;
   end else if (MODE_SEL == MODE_SKEW_FIX) begin : g_mode_skew
      logic unused_mode;
      assign unused_mode = pad_mode_i;
      assign mode_in     = 1'b1;
   end else begin : g_mode_flat
      logic unused_mode;
      assign unused_mode = pad_mode_i;
      assign mode_in     = 1'b0;
   end

   assign fill     = (phase_q == PH_FILL);
   // The mode follows the input only until the first row of a tile lands
   assign mode_eff = (fill && (row_q == '0)) ? mode_in : mode_q;
   assign ser_done = (ser_q == LAST);

   assign wr_fire  = wr_vld_i && fill;
   assign rd_rdy_o = !fill && (mode_eff || ser_done);
   assign rd_fire  = rd_vld_i && rd_rdy_o;
   assign ser_step = rd_vld_i && !fill && !mode_eff && !ser_done;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         phase_q <= PH_FILL;
         mode_q  <= 1'b1;
         row_q   <= '0;
         col_q   <= '0;
         ser_q   <= '0;
      end else begin
         mode_q <= mode_eff;
         if (wr_fire) begin
            if (row_q == LAST) begin
               row_q   <= '0;
               phase_q <= PH_DRAIN;
            end else begin
               row_q <= row_q + 1'b1;
            end
         end
         if (rd_fire) begin
            ser_q <= '0;
            if (col_q == LAST) begin
               col_q   <= '0;
               phase_q <= PH_FILL;
            end else begin
               col_q <= col_q + 1'b1;
            end
         end else if (ser_step) begin
            ser_q <= ser_q + 1'b1;
         end
      end
   end

   // Extra bank cycles: cleared when a new tile starts, one per serial step
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         conf_q <= '0;
      end else if (wr_fire && (row_q == '0)) begin
         conf_q <= '0;
      end else if (ser_step) begin
         conf_q <= conf_q + 1'b1;
      end
   end

   assign wr_rdy_o   = fill;
   assign wr_fire_o  = wr_fire;
   assign rd_fire_o  = rd_fire;
   assign ser_step_o = ser_step;
   assign drain_o    = !fill;
   assign skew_o     = mode_eff;
   assign row_o      = row_q;
   assign col_o      = col_q;
   assign ser_o      = ser_q;
   assign conf_o     = conf_q;

   AST_DRAIN_AFTER_FULL: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(phase_q == PH_DRAIN) |-> ($past(wr_fire) && ($past(row_q) == LAST)));   // R3
   AST_FILL_AFTER_LAST_COL: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(phase_q == PH_DRAIN) |-> ($past(rd_fire) && ($past(col_q) == LAST)));   // R9
   AST_CONF_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
      ser_step |=> (conf_q == $past(conf_q) + 1'b1));                               // R7
   AST_MODE_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
      (phase_q == PH_DRAIN) |=> $stable(mode_q) || $past(rd_fire));                 // R9

endmodule

// File: rtl/tbuf_transpose.sv
`timescale 1ns/1ps
// Corner-turn tile buffer: rows in, columns out, storage spread over skewed banks.
module tbuf_transpose
   import tbuf_pkg::*;
#(
   parameter int        DIM      = 32,
   parameter int        WORD_W   = 32,
   parameter mode_sel_e MODE_SEL = MODE_RUNTIME,
   parameter int        IW       = $clog2(DIM),
   parameter int        DW       = DIM * WORD_W,
   parameter int        CW       = $clog2(conf_max(DIM) + 1)
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          pad_mode_i,
   input  logic          wr_vld_i,
   input  logic [DW-1:0] wr_row_i,
   output logic          wr_rdy_o,
   input  logic          rd_vld_i,
   output logic          rd_rdy_o,
   output logic          rd_dvalid_o,
   output logic [DW-1:0] rd_data_o,
   output logic          drain_o,
   output logic [CW-1:0] conf_cnt_o
);

   if ((DIM < 2) || ((DIM & (DIM - 1)) != 0)) begin : g_chk_dim
      $error("tbuf_transpose: DIM must be a power of two and at least 2");
   end
   if (WORD_W < 1) begin : g_chk_word
      $error("tbuf_transpose: WORD_W must be positive");
   end

   logic          wr_fire;
   logic          rd_fire;
   logic          ser_step;
   logic          skew;
   logic [IW-1:0] row_idx;
   logic [IW-1:0] col_idx;
   logic [IW-1:0] ser_idx;
   logic          dvalid_q;

   logic [WORD_W-1:0] wr_word [DIM];
   logic [WORD_W-1:0] bank_rd [DIM];
   logic [WORD_W-1:0] out_q   [DIM];

   tbuf_ctrl #(
      .DIM      (DIM),
      .MODE_SEL (MODE_SEL),
      .IW       (IW),
      .CW       (CW)
   ) u_ctrl (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .pad_mode_i (pad_mode_i),
      .wr_vld_i   (wr_vld_i),
      .rd_vld_i   (rd_vld_i),
      .wr_rdy_o   (wr_rdy_o),
      .rd_rdy_o   (rd_rdy_o),
      .wr_fire_o  (wr_fire),
      .rd_fire_o  (rd_fire),
      .ser_step_o (ser_step),
      .drain_o    (drain_o),
      .skew_o     (skew),
      .row_o      (row_idx),
      .col_o      (col_idx),
      .ser_o      (ser_idx),
      .conf_o     (conf_cnt_o)
   );

   // Split the incoming row and pack the outgoing column
   for (genvar w = 0; w < DIM; w++) begin : g_lane
      assign wr_word[w]                   = wr_row_i[w*WORD_W +: WORD_W];
      assign rd_data_o[w*WORD_W +: WORD_W] = out_q[w];
   end

   // Per-bank address and write-data routing
   for (genvar b = 0; b < DIM; b++) begin : g_bank
      logic [IW-1:0]     wsel;
      logic [IW-1:0]     addr;
      logic [WORD_W-1:0] wdata;

      always_comb begin
         // skewed: bank b holds column (b - r) of row r; unskewed: column b
         wsel  = skew ? (IW'(b) - row_idx) : IW'(b);
         wdata = wr_word[wsel];
         if (!drain_o) begin
            addr = row_idx;
         end else if (skew) begin
            addr = IW'(b) - col_idx;   // row whose element of this column lives here
         end else begin
            addr = ser_idx;            // every bank walks the serial row index
         end
      end

      tbuf_bank #(
         .DEPTH  (DIM),
         .WORD_W (WORD_W),
         .AW     (IW)
      ) u_bank (
         .clk_i   (clk_i),
         .we_i    (wr_fire),
         .addr_i  (addr),
         .wdata_i (wdata),
         .rdata_o (bank_rd[b])
      );
   end

   // Column capture: all slots at once when skewed, one slot per cycle otherwise
   always_ff @(posedge clk_i) begin
      if (rd_fire && skew) begin
         for (int k = 0; k < DIM; k++) begin
            out_q[k] <= bank_rd[IW'(k) + col_idx];
         end
      end else if ((rd_fire || ser_step) && !skew) begin
         out_q[ser_idx] <= bank_rd[col_idx];
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         dvalid_q <= 1'b0;
      end else begin
         dvalid_q <= rd_fire;
      end
   end

   assign rd_dvalid_o = dvalid_q;

   AST_DATA_NEXT_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
      (rd_vld_i && rd_rdy_o) |=> rd_dvalid_o);                                       // R5
   AST_DATA_ONLY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (rst_i)
      rd_dvalid_o |-> $past(rd_vld_i && rd_rdy_o));                                  // R5
   AST_NO_DATA_WHILE_FILL: assert property (@(posedge clk_i) disable iff (rst_i)
      (!drain_o && $past(!drain_o)) |-> !rd_dvalid_o);                               // R3
   AST_SKEW_NO_CONFLICT: assert property (@(posedge clk_i) disable iff (rst_i)
      (drain_o && skew) |=> $stable(conf_cnt_o));                                    // R6
   AST_FLAT_SERIALISED: assert property (@(posedge clk_i) disable iff (rst_i)
      (rd_fire && !skew) |-> $past(ser_step));                                       // R7
   AST_NO_WRITE_IN_DRAIN: assert property (@(posedge clk_i) disable iff (rst_i)
      (drain_o && wr_vld_i) |-> !wr_rdy_o);                                          // R4

endmodule

// File: tb/tbuf_transpose_bench.sv
`timescale 1ns/1ps
module tbuf_transpose_bench;

   localparam int  DIM  = 32;
   localparam int  W    = 32;
   localparam int  DW   = DIM * W;
   localparam int  CW   = 10;
   localparam real TCLK = 5.0;

   logic          clk = 1'b0;
   logic          rst_i;
   logic          pad_mode_i;
   logic          wr_vld_i;
   logic [DW-1:0] wr_row_i;
   logic          wr_rdy_o;
   logic          rd_vld_i;
   logic          rd_rdy_o;
   logic          rd_dvalid_o;
   logic [DW-1:0] rd_data_o;
   logic          drain_o;
   logic [CW-1:0] conf_cnt_o;

   logic [W-1:0] mat [DIM][DIM];
   int vectors = 0;
   int fails   = 0;

   always #(TCLK / 2.0) clk = ~clk;

   tbuf_transpose u_tbuf_transpose (
      .clk_i       (clk),
      .rst_i       (rst_i),
      .pad_mode_i  (pad_mode_i),
      .wr_vld_i    (wr_vld_i),
      .wr_row_i    (wr_row_i),
      .wr_rdy_o    (wr_rdy_o),
      .rd_vld_i    (rd_vld_i),
      .rd_rdy_o    (rd_rdy_o),
      .rd_dvalid_o (rd_dvalid_o),
      .rd_data_o   (rd_data_o),
      .drain_o     (drain_o),
      .conf_cnt_o  (conf_cnt_o)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   function automatic int conf_expect(input bit skewed);
      return skewed ? 0 : DIM * (DIM - 1);
   endfunction

   // Fill one tile; mode0 is presented with the first row, later rows may flip it
   task automatic write_tile(input bit mode0, input bit flip, input bit poke_rd, input bit gaps);
      for (int r = 0; r < DIM; r++) begin
         @(negedge clk);
         if (gaps && ($urandom_range(0, 3) == 0)) begin
            wr_vld_i = 1'b0;
            @(negedge clk);
         end
         for (int c = 0; c < DIM; c++) begin
            mat[r][c] = $urandom;
            wr_row_i[c*W +: W] = mat[r][c];
         end
         wr_vld_i   = 1'b1;
         rd_vld_i   = poke_rd;
         pad_mode_i = (r == 0) ? mode0 : (flip ? ~mode0 : mode0);
         #1;
         check(wr_rdy_o == 1'b1, "R2", "row write ready", longint'(wr_rdy_o), 1);
         if (poke_rd) begin
            check(rd_rdy_o == 1'b0, "R3", "read ready during fill", longint'(rd_rdy_o), 0);
            check(rd_dvalid_o == 1'b0, "R3", "data during fill", longint'(rd_dvalid_o), 0);
         end
         if (r == 1) begin
            check(conf_cnt_o == '0, "R8", "counter cleared by first row", longint'(conf_cnt_o), 0);
         end
      end
      @(negedge clk);
      wr_vld_i = 1'b0;
      rd_vld_i = 1'b0;
      #1;
      check(drain_o == 1'b1, "R2", "drain after last row", longint'(drain_o), 1);
   endtask

   // Drain one tile, checking stall count and column contents
   task automatic drain_tile(input bit skewed, input bit poke_wr, input bit gaps);
      for (int j = 0; j < DIM; j++) begin
         int stalls;
         int bad;
         if (gaps && ($urandom_range(0, 3) == 0)) begin
            rd_vld_i = 1'b0;
            @(negedge clk);
         end
         rd_vld_i = 1'b1;
         pad_mode_i = $urandom_range(0, 1);
         if (poke_wr) begin
            wr_vld_i = 1'b1;
            for (int c = 0; c < DIM; c++) wr_row_i[c*W +: W] = $urandom;
         end
         stalls = 0;
         #1;
         while (!rd_rdy_o && stalls < 100) begin
            stalls++;
            @(negedge clk);
            #1;
         end
         if (poke_wr) begin
            check(wr_rdy_o == 1'b0, "R4", "write ready during drain", longint'(wr_rdy_o), 0);
         end
         if (skewed) check(stalls == 0, "R6", "skewed column stalls", stalls, 0);
         else        check(stalls == DIM - 1, "R7", "unskewed column stalls", stalls, DIM - 1);
         @(negedge clk);
         #1;
         check(rd_dvalid_o == 1'b1, "R5", "data valid after accept", longint'(rd_dvalid_o), 1);
         bad = -1;
         for (int r = 0; r < DIM; r++) begin
            if ((bad < 0) && (rd_data_o[r*W +: W] !== mat[r][j])) bad = r;
         end
         if (bad < 0) check(1'b1, "R5", "column data", 0, 0);
         else check(1'b0, "R5", $sformatf("column %0d word %0d", j, bad),
                    longint'(rd_data_o[bad*W +: W]), longint'(mat[bad][j]));
      end
      rd_vld_i = 1'b0;
      wr_vld_i = 1'b0;
      check(drain_o == 1'b0, "R9", "fill after last column", longint'(drain_o), 0);
      check(int'(conf_cnt_o) == conf_expect(skewed), skewed ? "R6" : "R7",
            "extra bank cycles per tile", longint'(conf_cnt_o), conf_expect(skewed));
   endtask

   initial begin
      #(TCLK * 150000);
      fails++;
      $display("FAIL R2 watchdog: act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'h1C0FFEE));
      rst_i      = 1'b1;
      pad_mode_i = 1'b1;
      wr_vld_i   = 1'b0;
      rd_vld_i   = 1'b0;
      wr_row_i   = '0;
      repeat (4) @(negedge clk);
      rst_i = 1'b0;
      #1;
      // R1: reset state
      check(drain_o == 1'b0, "R1", "phase after reset", longint'(drain_o), 0);
      check(wr_rdy_o == 1'b1, "R1", "write ready after reset", longint'(wr_rdy_o), 1);
      check(rd_rdy_o == 1'b0, "R1", "read ready after reset", longint'(rd_rdy_o), 0);
      check(rd_dvalid_o == 1'b0, "R1", "data valid after reset", longint'(rd_dvalid_o), 0);
      check(conf_cnt_o == '0, "R1", "counter after reset", longint'(conf_cnt_o), 0);

      // R3 barrier with reads requested throughout the fill, then skewed drain (R6)
      write_tile(1'b1, 1'b0, 1'b1, 1'b0);
      drain_tile(1'b1, 1'b0, 1'b0);

      // R7 unskewed tile, with writes presented during the drain (R4)
      write_tile(1'b0, 1'b0, 1'b0, 1'b0);
      drain_tile(1'b0, 1'b1, 1'b0);

      // R8: counter holds while idle
      repeat (3) @(negedge clk);
      #1;
      check(int'(conf_cnt_o) == conf_expect(1'b0), "R8", "counter held while idle",
            longint'(conf_cnt_o), conf_expect(1'b0));

      // R9: mode sampled only at the first row
      write_tile(1'b1, 1'b1, 1'b0, 1'b0);
      drain_tile(1'b1, 1'b0, 1'b0);
      write_tile(1'b0, 1'b1, 1'b0, 1'b0);
      drain_tile(1'b0, 1'b0, 1'b0);

      // Random tiles with gaps and pokes
      for (int t = 0; t < 6; t++) begin
         bit m;
         m = 1'($urandom_range(0, 1));
         write_tile(m, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'b1);
         drain_tile(m, 1'($urandom_range(0, 1)), 1'b1);
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule